// File: doc/BRIEF.md
# Power-delivery packet receiver and decoder

This block sits behind a biphase-mark clock-recovery stage and turns its recovered serial bits into a decoded packet. Bits arrive one at a time with a valid strobe inside a frame window (`frame_i` high while the line carries a transmission). The block first requires a run of alternating preamble bits. It then slides a 20-bit window over the stream until the window holds a recognised four-symbol ordered set. A regular start-of-packet is followed by 4b/5b decoding of a 16-bit header, up to seven 32-bit payload words and a 32-bit CRC. Decoding ends with a check of the end-of-packet code.

Every frame produces exactly one single-cycle `done_o` pulse with a status code. The code tells apart a good packet, a hard-reset ordered set, a cable-addressed start (reported as unsupported) and one error class for each place where decoding can fail. `pkt_ok_o` accompanies only a good packet.

The controller is a single state machine with these states:
- `S_IDLE`: waits for the first bit of a frame.
- `S_PRE`: counts alternating preamble bits.
- `S_HUNT`: slides the ordered-set window.
- `S_HDR`, `S_PAY` and `S_CRC`: collect symbols for the header, the payload words and the CRC word.
- `S_EOP`: checks the end-of-packet bits.
- `S_DRAIN`: ignores bits until the frame closes.

The state transitions are:
- IDLE→PRE on the first bit.
- PRE→HUNT after `PRE_BITS` alternating bits.
- HUNT→HDR on a start-of-packet match.
- HDR→PAY, or HDR→CRC when the count is zero.
- PAY→CRC after the last word.
- CRC→EOP on a CRC match.
- Any decision→DRAIN.
- DRAIN→IDLE on frame close.
- PRE, HUNT, HDR, PAY, CRC and EOP→IDLE when the frame closes early.

Top module: `pd_pkt_rx`

## Requirements
- R1: After reset `done_o`, `pkt_ok_o`, `status_o` and `header_o` are all zero.
- R2: The first `PRE_BITS` (default 16) bits of a frame must alternate. A repeated bit, or a frame that closes before the count is reached, gives status 3.
- R3: Bits are taken least significant first, so the first bit of a symbol is its bit 0. The start-of-packet match is the 5-bit symbols 0x18, 0x18, 0x18, 0x11 in arrival order. After it come four header symbols, lowest nibble first. The payload word count is header bits 14:12.
- R4: Data symbols decode as follows: 0x1E→0, 0x09→1, 0x14→2, 0x15→3, 0x0A→4, 0x0B→5, 0x0E→6, 0x0F→7, 0x12→8, 0x13→9, 0x16→A, 0x17→B, 0x1A→C, 0x1B→D, 0x1C→E, 0x1D→F.
- R5: Each payload word is eight symbols, lowest nibble first. Word k appears on `words_o[32k+31:32k]`.
- R6: The CRC is the reflected 0xEDB88320 polynomial. It starts from all ones, takes the header bits and then the payload bits least significant first, and is inverted at the end. It must equal the following eight-symbol word, or the status is 7.
- R7: Only the first four bits of the end-of-packet symbol are checked, and they must be 1,0,1,1. A mismatch, or a frame that closes before four bits arrive, gives status 8. Success gives status 0.
- R8: The symbol sequences 0x18, 0x18, 0x06, 0x06 and 0x18, 0x06, 0x18, 0x06 give status 2 and leave `header_o` and `words_o` unchanged.
- R9: The sequence 0x07, 0x07, 0x07, 0x19 gives status 1 and leaves `header_o` unchanged.
- R10: If no ordered set is matched within `HUNT_BITS` (default 128) bits after the preamble, or the frame closes while hunting, the status is 4.
- R11: If the frame closes during the header, payload or CRC, the status is 5.
- R12: A symbol outside the data table of R4, met in the header, payload or CRC, gives status 6.
- R13: Each frame gives exactly one `done_o` pulse, one cycle long. Bits after the decision are ignored until the frame closes.
- R14: `pkt_ok_o` is high only together with `done_o` and status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | High while a transmission is being received |
| bit_i | input | 1 | Recovered data bit |
| bit_vld_i | input | 1 | `bit_i` is valid this cycle |
| header_o | output | 16 | Last decoded header |
| words_o | output | PAY_WORDS*32 | Decoded payload words, word 0 lowest |
| status_o | output | 4 | Outcome code of the last frame |
| done_o | output | 1 | One-cycle pulse when a frame outcome is decided |
| pkt_ok_o | output | 1 | One-cycle pulse for a good packet |

## Verification
The hardest states to reach are the ones that need a long, well-formed prefix before the fault. Examples are a CRC that fails only after seven correctly coded words, a hunt that runs out after the preamble, and an end-of-packet whose fifth bit differs but must still pass. The bench therefore builds every frame from an encoder and a bit-serial CRC of its own. Each table row names a fault, and the bench injects it at exactly one point in an otherwise correct frame. For the "ignored" cases, a broken preamble is followed by a complete valid packet in the same frame, and only one pulse, with the preamble error, may appear.

// File: rtl/pdrx_pkg.sv
package pdrx_pkg;

    typedef enum logic [3:0] {
        ST_OK       = 4'd0,
        ST_HRST     = 4'd1,
        ST_UNSUP    = 4'd2,
        ST_ERR_PRE  = 4'd3,
        ST_ERR_SOP  = 4'd4,
        ST_ERR_LEN  = 4'd5,
        ST_ERR_SYM  = 4'd6,
        ST_ERR_CRC  = 4'd7,
        ST_ERR_EOP  = 4'd8
    } pdrx_status_e;

    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_HUNT, S_HDR, S_PAY, S_CRC, S_EOP, S_DRAIN
    } pdrx_state_e;

    typedef enum logic [1:0] {
        OS_NONE, OS_SOP, OS_ALT, OS_HRST
    } pdrx_os_e;

    localparam int SYM_BITS = 5;
    localparam logic [SYM_BITS-1:0] K_SYNC1 = 5'h18;
    localparam logic [SYM_BITS-1:0] K_SYNC2 = 5'h11;
    localparam logic [SYM_BITS-1:0] K_SYNC3 = 5'h06;
    localparam logic [SYM_BITS-1:0] K_RST1  = 5'h07;
    localparam logic [SYM_BITS-1:0] K_RST2  = 5'h19;
    localparam logic [SYM_BITS-1:0] K_EOP   = 5'h0D;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

endpackage

// File: rtl/pdrx_symdec.sv
module pdrx_symdec
    import pdrx_pkg::*;
(
    input  logic [SYM_BITS-1:0] code,
    output logic [3:0]          nib,
    output logic                is_data
);
    always_comb begin
        is_data = 1'b1;
        nib     = 4'h0;
        case (code)
            5'h1E: nib = 4'h0;
            5'h09: nib = 4'h1;
            5'h14: nib = 4'h2;
            5'h15: nib = 4'h3;
            5'h0A: nib = 4'h4;
            5'h0B: nib = 4'h5;
            5'h0E: nib = 4'h6;
            5'h0F: nib = 4'h7;
            5'h12: nib = 4'h8;
            5'h13: nib = 4'h9;
            5'h16: nib = 4'hA;
            5'h17: nib = 4'hB;
            5'h1A: nib = 4'hC;
            5'h1B: nib = 4'hD;
            5'h1C: nib = 4'hE;
            5'h1D: nib = 4'hF;
            default: is_data = 1'b0;
        endcase
    end
endmodule

// File: rtl/pdrx_osmatch.sv
module pdrx_osmatch
    import pdrx_pkg::*;
#(
    parameter int SET_SYMS = 4
) (
    input  logic [SET_SYMS*SYM_BITS-1:0] win,
    output pdrx_os_e                     cls
);
    logic [SET_SYMS-1:0] s1, s2, s3, r1, r2;

    for (genvar g = 0; g < SET_SYMS; g++) begin : g_sym
        assign s1[g] = (win[g*SYM_BITS +: SYM_BITS] == K_SYNC1);
        assign s2[g] = (win[g*SYM_BITS +: SYM_BITS] == K_SYNC2);
        assign s3[g] = (win[g*SYM_BITS +: SYM_BITS] == K_SYNC3);
        assign r1[g] = (win[g*SYM_BITS +: SYM_BITS] == K_RST1);
        assign r2[g] = (win[g*SYM_BITS +: SYM_BITS] == K_RST2);
    end

    logic is_sop, is_p1, is_p2, is_hr;
    assign is_sop = s1[0] & s1[1] & s1[2] & s2[3];
    assign is_p1  = s1[0] & s1[1] & s3[2] & s3[3];
    assign is_p2  = s1[0] & s3[1] & s1[2] & s3[3];
    assign is_hr  = r1[0] & r1[1] & r1[2] & r2[3];

    always_comb begin
        if (is_sop)              cls = OS_SOP;
        else if (is_p1 || is_p2) cls = OS_ALT;
        else if (is_hr)          cls = OS_HRST;
        else                     cls = OS_NONE;
    end
endmodule

// File: rtl/pdrx_crc32.sv
module pdrx_crc32
    import pdrx_pkg::*;
#(
    parameter int DIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             adv,
    input  logic [DIN_W-1:0] din,
    output logic [31:0]      crc_q
);
    logic [31:0] nxt;

    always_comb begin
        nxt = crc_q;
        for (int i = 0; i < DIN_W; i++) begin
            if (nxt[0] ^ din[i]) nxt = (nxt >> 1) ^ CRC_POLY;
            else                 nxt = nxt >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= '1;
        else if (init) crc_q <= '1;
        else if (adv)  crc_q <= nxt;
    end
endmodule

// File: rtl/pd_pkt_rx.sv
module pd_pkt_rx
    import pdrx_pkg::*;
#(
    parameter int PRE_BITS  = 16,
    parameter int HUNT_BITS = 128,
    parameter int PAY_WORDS = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_i,
    input  logic                   bit_i,
    input  logic                   bit_vld_i,
    output logic [15:0]            header_o,
    output logic [PAY_WORDS*32-1:0] words_o,
    output logic [3:0]             status_o,
    output logic                   done_o,
    output logic                   pkt_ok_o
);
    localparam int SET_SYMS = 4;
    localparam int WIN_W    = SET_SYMS * SYM_BITS;
    localparam int PRE_W    = $clog2(PRE_BITS + 1);
    localparam int HUNT_W   = $clog2(HUNT_BITS + 1);
    localparam int CNT_W    = 3;
    localparam int NIB_W    = 3;

    pdrx_state_e      state_q, state_d;
    logic             fin;
    pdrx_status_e     fin_code;
    logic             bit_tk, in_data, sym_end, hdr_end, word_end, cnt_over;
    logic [2:0]       bitc_q;
    logic [3:0]       sym_sr_q;
    logic [4:0]       sym_full;
    logic [3:0]       eop4;
    logic [3:0]       dec_nib;
    logic             dec_ok;
    logic [NIB_W-1:0] nibc_q;
    logic [31:0]      acc_q, word_full;
    logic [CNT_W-1:0] wordc_q, cnt_q, hdr_cnt;
    logic [PRE_W-1:0] pre_cnt_q;
    logic             prev_q;
    logic [HUNT_W-1:0] hunt_q;
    logic [WIN_W-1:0] win_q, win_d;
    pdrx_os_e         os_cls;
    logic [31:0]      crc_q;
    logic             crc_init, crc_adv;
    logic [31:0]      words_q [PAY_WORDS];

    assign bit_tk    = frame_i & bit_vld_i;
    assign in_data   = (state_q == S_HDR) || (state_q == S_PAY) ||
                       (state_q == S_CRC) || (state_q == S_EOP);
    assign sym_full  = {bit_i, sym_sr_q};
    assign eop4      = {bit_i, sym_sr_q[3:1]};
    assign sym_end   = bit_tk && (bitc_q == 3'd4);
    assign word_full = {dec_nib, acc_q[31:4]};
    assign hdr_cnt   = word_full[30:28];
    assign hdr_end   = sym_end && dec_ok && (nibc_q == 3'd3);
    assign word_end  = sym_end && dec_ok && (nibc_q == 3'd7);
    assign win_d     = {bit_i, win_q[WIN_W-1:1]};

    if (PAY_WORDS < 7) begin : g_lim
        assign cnt_over = (hdr_cnt > CNT_W'(PAY_WORDS));
    end else begin : g_nolim
        assign cnt_over = 1'b0;
    end

    pdrx_symdec u_dec (.code(sym_full), .nib(dec_nib), .is_data(dec_ok));

    pdrx_osmatch #(.SET_SYMS(SET_SYMS)) u_os (.win(win_d), .cls(os_cls));

    assign crc_init = (state_q == S_HUNT) && bit_tk && (os_cls == OS_SOP);
    assign crc_adv  = sym_end && dec_ok && ((state_q == S_HDR) || (state_q == S_PAY));

    pdrx_crc32 #(.DIN_W(4)) u_crc (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .adv(crc_adv),
        .din(dec_nib), .crc_q(crc_q)
    );

    // next state and outcome
    always_comb begin
        state_d  = state_q;
        fin      = 1'b0;
        fin_code = ST_OK;
        unique case (state_q)
            S_IDLE: if (bit_tk) state_d = S_PRE;
            S_PRE: begin
                if (!frame_i) begin
                    fin = 1'b1; fin_code = ST_ERR_PRE; state_d = S_IDLE;
                end else if (bit_vld_i) begin
                    if (bit_i == prev_q) begin
                        fin = 1'b1; fin_code = ST_ERR_PRE; state_d = S_DRAIN;
                    end else if (pre_cnt_q == PRE_W'(PRE_BITS - 1)) begin
                        state_d = S_HUNT;
                    end
                end
            end
            S_HUNT: begin
                if (!frame_i) begin
                    fin = 1'b1; fin_code = ST_ERR_SOP; state_d = S_IDLE;
                end else if (bit_vld_i) begin
                    unique case (os_cls)
                        OS_SOP:  state_d = S_HDR;
                        OS_ALT:  begin fin = 1'b1; fin_code = ST_UNSUP; state_d = S_DRAIN; end
                        OS_HRST: begin fin = 1'b1; fin_code = ST_HRST;  state_d = S_DRAIN; end
                        OS_NONE: if (hunt_q == HUNT_W'(HUNT_BITS - 1)) begin
                            fin = 1'b1; fin_code = ST_ERR_SOP; state_d = S_DRAIN;
                        end
                    endcase
                end
            end
            S_HDR, S_PAY, S_CRC: begin
                if (!frame_i) begin
                    fin = 1'b1; fin_code = ST_ERR_LEN; state_d = S_IDLE;
                end else if (sym_end && !dec_ok) begin
                    fin = 1'b1; fin_code = ST_ERR_SYM; state_d = S_DRAIN;
                end else if (state_q == S_HDR && hdr_end) begin
                    if (cnt_over) begin
                        fin = 1'b1; fin_code = ST_ERR_LEN; state_d = S_DRAIN;
                    end else begin
                        state_d = (hdr_cnt == '0) ? S_CRC : S_PAY;
                    end
                end else if (state_q == S_PAY && word_end) begin
                    if (wordc_q + 3'd1 == cnt_q) state_d = S_CRC;
                end else if (state_q == S_CRC && word_end) begin
                    if (word_full == ~crc_q) state_d = S_EOP;
                    else begin fin = 1'b1; fin_code = ST_ERR_CRC; state_d = S_DRAIN; end
                end
            end
            S_EOP: begin
                if (!frame_i) begin
                    fin = 1'b1; fin_code = ST_ERR_EOP; state_d = S_IDLE;
                end else if (bit_vld_i && bitc_q == 3'd3) begin
                    fin = 1'b1;
                    fin_code = (eop4 == K_EOP[3:0]) ? ST_OK : ST_ERR_EOP;
                    state_d = S_DRAIN;
                end
            end
            S_DRAIN: if (!frame_i) state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            pkt_ok_o  <= 1'b0;
            status_o  <= ST_OK;
            header_o  <= '0;
            sym_sr_q  <= '0;
            prev_q    <= 1'b0;
            win_q     <= '0;
            bitc_q    <= '0;
            nibc_q    <= '0;
            acc_q     <= '0;
            wordc_q   <= '0;
            cnt_q     <= '0;
            pre_cnt_q <= '0;
            hunt_q    <= '0;
            for (int i = 0; i < PAY_WORDS; i++) words_q[i] <= '0;
        end else begin
            done_o   <= fin;
            pkt_ok_o <= fin && (fin_code == ST_OK);
            if (fin) status_o <= fin_code;
            if (bit_tk) begin
                sym_sr_q <= {bit_i, sym_sr_q[3:1]};
                prev_q   <= bit_i;
                win_q    <= win_d;
            end
            if (state_q == S_IDLE)          pre_cnt_q <= bit_tk ? PRE_W'(1) : '0;
            else if (state_q == S_PRE && bit_tk) pre_cnt_q <= pre_cnt_q + 1'b1;
            if (state_q != S_HUNT)          hunt_q <= '0;
            else if (bit_tk)                hunt_q <= hunt_q + 1'b1;
            if (!in_data)                   bitc_q <= '0;
            else if (bit_tk)                bitc_q <= (bitc_q == 3'd4) ? 3'd0 : bitc_q + 3'd1;
            if (!in_data)                   nibc_q <= '0;
            else if (sym_end && dec_ok)     nibc_q <= hdr_end && state_q == S_HDR ? '0 : nibc_q + 1'b1;
            if (sym_end)                    acc_q <= word_full;
            if (state_q == S_HDR && hdr_end) begin
                header_o <= word_full[31:16];
                cnt_q    <= hdr_cnt;
            end
            if (!in_data)                   wordc_q <= '0;
            else if (state_q == S_PAY && word_end) begin
                words_q[wordc_q] <= word_full;
                wordc_q          <= wordc_q + 3'd1;
            end
        end
    end

    for (genvar g = 0; g < PAY_WORDS; g++) begin : g_out
        assign words_o[g*32 +: 32] = words_q[g];
    end

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R14
    pkt_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ok_o |-> (done_o && status_o == ST_OK));
    // R10
    hunt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HUNT) |-> (hunt_q < HUNT_W'(HUNT_BITS)));
    // R5
    word_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PAY) |-> (wordc_q < cnt_q));
    // R8
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HUNT) |=> $stable(header_o));

endmodule

// File: tb/pd_pkt_rx_tb_top.sv
module pd_pkt_rx_tb_top;
    localparam int PAY_WORDS = 7;
    localparam int NVEC = 12;
    // {mode, expected status, header, seed}
    localparam logic [55:0] VEC [NVEC] = '{
        {4'd0, 4'd0, 16'h1041, 32'h0000_1111},
        {4'd0, 4'd0, 16'h0C2F, 32'h2468_ACE0},
        {4'd0, 4'd0, 16'h7ABC, 32'hDEAD_BEEF},
        {4'd1, 4'd7, 16'h3123, 32'h1357_9BDF},
        {4'd2, 4'd8, 16'h1F00, 32'h0F0F_F0F0},
        {4'd3, 4'd5, 16'h4E11, 32'hCAFE_0001},
        {4'd4, 4'd2, 16'h1111, 32'h0},
        {4'd6, 4'd1, 16'h0000, 32'h0},
        {4'd7, 4'd6, 16'h2222, 32'h5555_AAAA},
        {4'd8, 4'd3, 16'h1234, 32'h7777_0000},
        {4'd9, 4'd0, 16'h5A5A, 32'h8181_2323},
        {4'd5, 4'd2, 16'h0000, 32'h0}
    };

    logic clk = 0, rst_n = 0, frame = 0, bit_b = 0, vld = 0;
    logic [15:0] header_o;
    logic [PAY_WORDS*32-1:0] words_o;
    logic [3:0] status_o;
    logic done_o, pkt_ok_o;

    pd_pkt_rx dut_i (
        .clk(clk), .rst_n(rst_n), .frame_i(frame), .bit_i(bit_b), .bit_vld_i(vld),
        .header_o(header_o), .words_o(words_o), .status_o(status_o),
        .done_o(done_o), .pkt_ok_o(pkt_ok_o)
    );

    always #4 clk = ~clk;

    int n_tests = 0, n_fail = 0, pulses = 0;
    logic [3:0] last_st = '0;
    logic last_ok = 0;
    bit finished = 0;

    always @(negedge clk) begin
        if (rst_n && done_o) begin
            pulses++;
            last_st = status_o;
            last_ok = pkt_ok_o;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] enc5(input logic [3:0] n);
        case (n)
            4'h0: return 5'h1E; 4'h1: return 5'h09; 4'h2: return 5'h14; 4'h3: return 5'h15;
            4'h4: return 5'h0A; 4'h5: return 5'h0B; 4'h6: return 5'h0E; 4'h7: return 5'h0F;
            4'h8: return 5'h12; 4'h9: return 5'h13; 4'hA: return 5'h16; 4'hB: return 5'h17;
            4'hC: return 5'h1A; 4'hD: return 5'h1B; 4'hE: return 5'h1C; default: return 5'h1D;
        endcase
    endfunction

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [31:0] d, input int n);
        logic [31:0] r = c;
        for (int i = 0; i < n; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [31:0] pw(input logic [31:0] seed, input int i);
        return seed ^ (32'h9E37_79B9 * (i + 1));
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk); bit_b = b; vld = 1;
        @(negedge clk); vld = 0;
    endtask

    task automatic send_sym(input logic [4:0] s);
        for (int i = 0; i < 5; i++) send_bit(s[i]);
    endtask

    task automatic send_val(input logic [31:0] w, input int nnib);
        for (int k = 0; k < nnib; k++) send_sym(enc5(w[4*k +: 4]));
    endtask

    task automatic preamble();
        for (int i = 0; i < 64; i++) send_bit(i[0]);
    endtask

    task automatic close_frame();
        repeat (4) @(negedge clk);
        frame = 0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_packet(input int mode, input logic [15:0] hdr, input logic [31:0] seed);
        int cnt;
        logic [31:0] crc;
        cnt = int'(hdr[14:12]);
        @(negedge clk); frame = 1;
        if (mode == 8) begin
            send_bit(0); send_bit(1); send_bit(0); send_bit(0);
        end
        preamble();
        if (mode == 4) begin
            send_sym(5'h18); send_sym(5'h18); send_sym(5'h06); send_sym(5'h06);
        end else if (mode == 5) begin
            send_sym(5'h18); send_sym(5'h06); send_sym(5'h18); send_sym(5'h06);
        end else if (mode == 6) begin
            send_sym(5'h07); send_sym(5'h07); send_sym(5'h07); send_sym(5'h19);
        end else begin
            send_sym(5'h18); send_sym(5'h18); send_sym(5'h18); send_sym(5'h11);
            crc = crc_upd(32'hFFFF_FFFF, {16'h0, hdr}, 16);
            if (mode == 7) begin
                send_sym(5'h1F);
                send_val({20'h0, hdr[15:4]}, 3);
            end else begin
                send_val({16'h0, hdr}, 4);
            end
            for (int i = 0; i < cnt; i++) begin
                if (mode == 3 && i == 1) break;
                send_val(pw(seed, i), 8);
                crc = crc_upd(crc, pw(seed, i), 32);
            end
            if (mode != 3) begin
                crc = ~crc;
                if (mode == 1) crc[0] = ~crc[0];
                send_val(crc, 8);
                if (mode == 2)      send_sym(5'h0E);
                else if (mode == 9) send_sym(5'h1D);
                else                send_sym(5'h0D);
            end
        end
        close_frame();
    endtask

    function automatic string req_of(input int mode);
        case (mode)
            0: return "R5"; 1: return "R6"; 2: return "R7"; 3: return "R11";
            4: return "R8"; 5: return "R8"; 6: return "R9"; 7: return "R12";
            8: return "R2"; default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R13 watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int p0;
        logic [15:0] prev_hdr;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R1 reset values
        chk("R1", "done", done_o, 0);
        chk("R1", "pkt_ok", pkt_ok_o, 0);
        chk("R1", "status", status_o, 0);
        chk("R1", "header", header_o, 0);

        for (int v = 0; v < NVEC; v++) begin
            int mode, cnt;
            logic [3:0] exp;
            mode = int'(VEC[v][55:52]);
            exp = VEC[v][51:48];
            prev_hdr = header_o;
            p0 = pulses;
            send_packet(mode, VEC[v][47:32], VEC[v][31:0]);
            chk("R13", "pulse count", pulses - p0, 1);
            chk(req_of(mode), "status", last_st, exp);
            chk("R14", "pkt_ok", last_ok, exp == 4'd0);
            if (exp == 4'd0) begin
                cnt = int'(VEC[v][46:44]);
                chk("R4", "header", header_o, VEC[v][47:32]);
                for (int i = 0; i < cnt; i++)
                    chk("R5", "payload word", words_o[32*i +: 32], pw(VEC[v][31:0], i));
            end
            if (mode == 4 || mode == 5) chk("R8", "header held", header_o, prev_hdr);
            if (mode == 6) chk("R9", "header held", header_o, prev_hdr);
        end

        // R3 header count 7 fills the last payload slot
        send_packet(0, 16'h7001, 32'h0BAD_F00D);
        chk("R3", "last word", words_o[32*6 +: 32], pw(32'h0BAD_F00D, 6));

        // R10 frame closes while hunting
        p0 = pulses;
        @(negedge clk); frame = 1;
        preamble();
        close_frame();
        chk("R10", "status close in hunt", last_st, 4);
        chk("R13", "pulse count hunt", pulses - p0, 1);

        // R10 hunt limit reached with frame still open
        p0 = pulses;
        @(negedge clk); frame = 1;
        for (int i = 0; i < 204; i++) send_bit(i[0]);
        repeat (3) @(negedge clk);
        chk("R10", "hunt limit pulse before close", pulses - p0, 1);
        chk("R10", "status hunt limit", last_st, 4);
        close_frame();
        chk("R13", "no second pulse", pulses - p0, 1);

        // R7 frame closes inside end-of-packet
        begin
            logic [31:0] crc;
            p0 = pulses;
            @(negedge clk); frame = 1;
            preamble();
            send_sym(5'h18); send_sym(5'h18); send_sym(5'h18); send_sym(5'h11);
            send_val({16'h0, 16'h0C05}, 4);
            crc = ~crc_upd(32'hFFFF_FFFF, {16'h0, 16'h0C05}, 16);
            send_val(crc, 8);
            send_bit(1); send_bit(0);
            close_frame();
            chk("R7", "status short eop", last_st, 8);
            chk("R14", "pkt_ok short eop", last_ok, 0);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule